// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when the rest of the chip may leave reset. The chip is held in reset after a power-on pulse, a qualified brown-out or a low external reset pin, and is held after a wake event while the oscillator settles. Up to three delays run one after another: a power-up delay, an oscillator start-up count and a PLL lock delay. The oscillator mode and the cause of the reset decide which of these delays run.

The power-up and PLL delays count cycles of the slow reference clock `clk_i`. The start-up delay counts pulses of `osc_tick_i`, which gives one pulse for each cycle of the oscillator input. All three lengths are parameters, so a short test can use small values. Supply sensing happens outside the block. It arrives here as the digital comparator flag `bor_low_i`. A one-hot cause vector records why the latest reset or hold began, and it stays valid after the chip leaves reset.

Top module: `rst_tmo_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first `por_i` pulse, `chip_rst_o` is 1 and `cause_o` is 0.
- R2: After a `por_i` pulse the delays run in a fixed order. First comes the power-up delay of PWRT_CYC clocks, but only if `pwrt_en_i` is 1. Next comes the start-up delay of OST_CYC ticks, in the crystal modes 0 to 3 only. Last comes the PLL delay of PLL_CYC clocks, in mode 3 only. Each clock edge is one clock. The encoding of `osc_mode_i` is: 0 low-power crystal, 1 mid crystal, 2 high-speed crystal, 3 high-speed crystal with PLL, 4 RC, 5 RC with spare pin, 6 external clock, 7 external clock with spare pin.
- R3: In modes 4 to 7 with `pwrt_en_i` at 0, a `por_i` pulse starts no delay. Reset ends at the clock edge that samples the pulse.
- R4: While the chip runs, a brown-out causes a reset only when `bor_low_i` is high for BOR_QUAL clock edges in a row while `bor_en_i` is 1. A shorter dip has no effect. Any dip has no effect while `bor_en_i` is 0.
- R5: After a brown-out the chip stays in reset while `bor_low_i` is high. Once `bor_low_i` falls, only the power-up delay runs, even in crystal modes. When `pwrt_en_i` is 0, reset ends at once.
- R6: The supply can dip again (`bor_low_i` high with `bor_en_i` 1) while any delay is running. The block then goes back to brown-out hold, and the next recovery starts a full power-up delay.
- R7: The delays keep running while `ext_rst_ni` is low, and `chip_rst_o` stays 1 for as long as the pin is low. If the pin is released after the delays have ended, `chip_rst_o` falls in the same cycle, with no clock edge needed.
- R8: If `ext_rst_ni` falls while the chip runs, `chip_rst_o` is 1 while the pin is low. Releasing the pin starts no delay.
- R9: A `wake_i` pulse while the chip runs starts the start-up delay, followed by the PLL delay in mode 3. This happens in crystal modes only. In modes 4 to 7 a wake pulse causes no hold, and a wake never runs the power-up delay.
- R10: `cause_o` is one-hot: bit 0 power-on, bit 1 brown-out, bit 2 external pin, bit 3 wake. It is overwritten when a new reset or hold begins, and it keeps its value after release.
- R11: The start-up delay advances only on clock edges where `osc_tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| por_i | input | 1 | Power-on pulse, restarts the delay chain |
| bor_low_i | input | 1 | Supply below brown-out threshold |
| bor_en_i | input | 1 | Brown-out detection enable |
| ext_rst_ni | input | 1 | Filtered external reset pin, active low |
| wake_i | input | 1 | Wake-from-sleep event |
| osc_tick_i | input | 1 | One pulse per oscillator input cycle |
| osc_mode_i | input | 3 | Oscillator mode, encoding in R2 |
| pwrt_en_i | input | 1 | Power-up delay enable |
| chip_rst_o | output | 1 | Chip held in reset or hold |
| cause_o | output | 4 | One-hot cause of the latest reset or hold |

## Verification
The hardest case to reach is a second supply dip that lands inside the recovery delay after a brown-out. To get there, the stimulus first holds the comparator flag long enough to qualify a brown-out, then releases it. Ten clocks into the power-up delay it raises the flag for a single edge. The bench then checks that the next release again takes the full delay. Two other cases need care in the stimulus. The pin is held low past the end of the timers, and the start-up count is driven by a tick that toggles on every clock, which shows that this delay counts ticks and not clocks.

// File: rtl/rst_tmo_pkg.sv
package rst_tmo_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_BOR,
    ST_PWRT,
    ST_OST,
    ST_PLL,
    ST_RUN
  } seq_st_e;

  localparam logic [3:0] CAUSE_POR  = 4'b0001;
  localparam logic [3:0] CAUSE_BOR  = 4'b0010;
  localparam logic [3:0] CAUSE_EXT  = 4'b0100;
  localparam logic [3:0] CAUSE_WAKE = 4'b1000;

  localparam logic [2:0] OSC_XTAL_PLL = 3'd3;

  function automatic logic is_xtal(logic [2:0] mode);
    return !mode[2];
  endfunction

  function automatic logic is_pll(logic [2:0] mode);
    return mode == OSC_XTAL_PLL;
  endfunction

endpackage

// File: rtl/rst_tmo_timer.sv
module rst_tmo_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || done_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + CW'(1);
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i != '0) |-> (cnt_q < limit_i))
    else $error("timer count beyond its limit");

endmodule

// File: rtl/rst_tmo_bor_filt.sv
module rst_tmo_bor_filt #(
  parameter int unsigned QUAL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bor_low_i,
  input  logic bor_en_i,
  output logic trip_o
);

  localparam int unsigned QW = $clog2(QUAL + 1);

  logic [QW-1:0] qcnt_q;
  logic          low_act;

  assign low_act = bor_low_i && bor_en_i;
  assign trip_o  = low_act && (qcnt_q == QW'(QUAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        qcnt_q <= '0;
    else if (!low_act)                  qcnt_q <= '0;
    else if (qcnt_q != QW'(QUAL - 1))   qcnt_q <= qcnt_q + QW'(1);
  end

  // needs QUAL >= 2: a trip implies the flag was already high one edge earlier
  p_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> ($past(bor_low_i) && $past(bor_en_i)))
    else $error("brown-out tripped without a qualifying run");

endmodule

// File: rtl/rst_tmo_seq.sv
module rst_tmo_seq
  import rst_tmo_pkg::*;
#(
  parameter int unsigned PWRT_CYC = 72000,
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned PLL_CYC  = 2000,
  parameter int unsigned BOR_QUAL = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       bor_low_i,
  input  logic       bor_en_i,
  input  logic       ext_rst_ni,
  input  logic       wake_i,
  input  logic       osc_tick_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output logic       chip_rst_o,
  output logic [3:0] cause_o
);

  localparam int unsigned MAX_AB = (PWRT_CYC > PLL_CYC) ? PWRT_CYC : PLL_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > OST_CYC) ? MAX_AB : OST_CYC;
  localparam int unsigned CW     = $clog2(MAX_C + 1);

  seq_st_e       st_q, st_d;
  logic [3:0]    cause_q, cause_d;
  logic          osc_q, osc_d;   // sequence may include start-up/PLL delays
  logic          ext_q;
  logic          restart;
  logic          timed;
  logic          tmr_tick, tmr_clr, tmr_done;
  logic [CW-1:0] tmr_lim;
  logic          bor_trip;
  logic          dip;
  logic          xtal, pll;

  assign xtal = is_xtal(osc_mode_i);
  assign pll  = is_pll(osc_mode_i);
  assign dip  = bor_en_i && bor_low_i;

  rst_tmo_bor_filt #(.QUAL(BOR_QUAL)) u_bor_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bor_low_i (bor_low_i),
    .bor_en_i  (bor_en_i),
    .trip_o    (bor_trip)
  );

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    osc_d   = osc_q;
    restart = 1'b0;
    if (por_i) begin
      cause_d = CAUSE_POR;
      osc_d   = 1'b1;
      restart = 1'b1;
      st_d    = pwrt_en_i ? ST_PWRT : (xtal ? ST_OST : ST_RUN);
    end else begin
      unique case (st_q)
        ST_OFF: ;
        ST_BOR: if (!dip) st_d = pwrt_en_i ? ST_PWRT : ST_RUN;
        ST_PWRT, ST_OST, ST_PLL: begin
          if (dip) begin
            st_d    = ST_BOR;
            cause_d = CAUSE_BOR;
            osc_d   = 1'b0;
          end else if (tmr_done) begin
            unique case (st_q)
              ST_PWRT: st_d = (osc_q && xtal) ? ST_OST : ST_RUN;
              ST_OST:  st_d = pll ? ST_PLL : ST_RUN;
              default: st_d = ST_RUN;
            endcase
          end
        end
        ST_RUN: begin
          if (bor_trip) begin
            st_d    = ST_BOR;
            cause_d = CAUSE_BOR;
            osc_d   = 1'b0;
          end else if (wake_i) begin
            cause_d = CAUSE_WAKE;
            osc_d   = 1'b1;
            restart = 1'b1;
            st_d    = xtal ? ST_OST : ST_RUN;
          end else if (ext_q && !ext_rst_ni) begin
            cause_d = CAUSE_EXT;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  assign timed    = (st_q == ST_PWRT) || (st_q == ST_OST) || (st_q == ST_PLL);
  assign tmr_tick = timed && ((st_q != ST_OST) || osc_tick_i);
  assign tmr_clr  = restart || (st_d != st_q) || !timed;

  always_comb begin
    unique case (st_q)
      ST_PWRT: tmr_lim = CW'(PWRT_CYC);
      ST_OST:  tmr_lim = CW'(OST_CYC);
      ST_PLL:  tmr_lim = CW'(PLL_CYC);
      default: tmr_lim = CW'(1);
    endcase
  end

  rst_tmo_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clr),
    .tick_i  (tmr_tick),
    .limit_i (tmr_lim),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      cause_q <= '0;
      osc_q   <= 1'b0;
      ext_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      osc_q   <= osc_d;
      ext_q   <= ext_rst_ni;
    end
  end

  // pin gates the output directly so release is immediate
  assign chip_rst_o = (st_q != ST_RUN) || !ext_rst_ni;
  assign cause_o    = cause_q;

  p_cause_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o))
    else $error("cause not one-hot");

  p_por_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (cause_o == CAUSE_POR))
    else $error("power-on cause not recorded");

  p_dip_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed && dip && !por_i) |=> (st_q == ST_BOR))
    else $error("dip during delay did not re-enter hold");

  p_hold_bor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_BOR) && dip && !por_i) |=> chip_rst_o)
    else $error("released during brown-out");

  p_pin_no_timer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rst_ni && (st_q == ST_RUN) && !por_i && !bor_trip && !wake_i) |=> (st_q == ST_RUN))
    else $error("pin started a delay");

  p_wake_no_pwrt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN) && wake_i && !por_i && !bor_trip) |=> (st_q != ST_PWRT))
    else $error("wake ran power-up delay");

endmodule

// File: tb/rst_tmo_seq_tb.sv
module rst_tmo_seq_tb;

  localparam int PWRT = 20;
  localparam int OST  = 8;
  localparam int PLL  = 6;
  localparam int QUAL = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_i = 1'b0;
  logic       bor_low_i = 1'b0;
  logic       bor_en_i = 1'b1;
  logic       ext_rst_ni = 1'b1;
  logic       wake_i = 1'b0;
  logic       osc_tick_i = 1'b1;
  logic [2:0] osc_mode_i = 3'd0;
  logic       pwrt_en_i = 1'b1;
  logic       chip_rst_o;
  logic [3:0] cause_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_tmo_seq #(
    .PWRT_CYC (PWRT),
    .OST_CYC  (OST),
    .PLL_CYC  (PLL),
    .BOR_QUAL (QUAL)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .bor_low_i  (bor_low_i),
    .bor_en_i   (bor_en_i),
    .ext_rst_ni (ext_rst_ni),
    .wake_i     (wake_i),
    .osc_tick_i (osc_tick_i),
    .osc_mode_i (osc_mode_i),
    .pwrt_en_i  (pwrt_en_i),
    .chip_rst_o (chip_rst_o),
    .cause_o    (cause_o)
  );

  // {mode[2:0], pwrt_en, expected held cycles[7:0]}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 1'b1, 8'd28},
    {3'd1, 1'b0, 8'd8},
    {3'd3, 1'b1, 8'd34},
    {3'd3, 1'b0, 8'd14},
    {3'd4, 1'b1, 8'd20},
    {3'd4, 1'b0, 8'd0},
    {3'd6, 1'b0, 8'd0},
    {3'd7, 1'b1, 8'd20}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    while (chip_rst_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_por(output int n);
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    measure(n);
  endtask

  task automatic pulse_wake(output int n);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    measure(n);
  endtask

  task automatic trip_bor();
    bor_low_i = 1'b1;
    repeat (QUAL + 2) @(negedge clk);
  endtask

  task automatic release_bor(output int n);
    bor_low_i = 1'b0;
    @(negedge clk);
    measure(n);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset rst", int'(chip_rst_o), 1);
    check("R1 reset cause", int'(cause_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 waits for por", int'(chip_rst_o), 1);

    // R2 R3 table of power-on sequences
    for (int i = 0; i < 8; i++) begin
      osc_mode_i = VEC[i][11:9];
      pwrt_en_i  = VEC[i][8];
      @(negedge clk);
      pulse_por(n);
      check($sformatf("R2 R3 por vec %0d", i), n, int'(VEC[i][7:0]));
      check("R10 por cause", int'(cause_o), 1);
    end

    // R4 short dip
    osc_mode_i = 3'd0;
    pwrt_en_i  = 1'b1;
    bor_low_i  = 1'b1;
    repeat (QUAL - 1) @(negedge clk);
    bor_low_i = 1'b0;
    @(negedge clk);
    check("R4 short dip ignored", int'(chip_rst_o), 0);
    check("R4 short dip cause", int'(cause_o), 1);

    // R4 detection disabled
    bor_en_i = 1'b0;
    bor_low_i = 1'b1;
    repeat (10) @(negedge clk);
    check("R4 disabled dip", int'(chip_rst_o), 0);
    bor_low_i = 1'b0;
    @(negedge clk);
    bor_en_i = 1'b1;
    @(negedge clk);

    // R5 qualified brown-out, crystal mode still no start-up delay
    trip_bor();
    check("R5 bor held", int'(chip_rst_o), 1);
    check("R10 bor cause", int'(cause_o), 2);
    repeat (5) @(negedge clk);
    check("R5 bor still held", int'(chip_rst_o), 1);
    release_bor(n);
    check("R5 bor recovery len", n, PWRT);

    // R6 dip during recovery delay
    trip_bor();
    bor_low_i = 1'b0;
    repeat (11) @(negedge clk);
    check("R6 inside delay", int'(chip_rst_o), 1);
    bor_low_i = 1'b1;
    @(negedge clk);
    release_bor(n);
    check("R6 restarted full delay", n, PWRT);

    // R5 recovery with power-up delay disabled
    pwrt_en_i = 1'b0;
    trip_bor();
    release_bor(n);
    check("R5 no pwrt recovery", n, 0);
    pwrt_en_i = 1'b1;

    // R7 pin held past expiry
    ext_rst_ni = 1'b0;
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 pin holds", int'(chip_rst_o), 1);
    ext_rst_ni = 1'b1;
    #1;
    check("R7 immediate release", int'(chip_rst_o), 0);
    check("R10 cause kept por", int'(cause_o), 1);
    @(negedge clk);

    // R8 pin reset while running
    ext_rst_ni = 1'b0;
    #1;
    check("R8 pin asserts", int'(chip_rst_o), 1);
    @(negedge clk);
    check("R10 ext cause", int'(cause_o), 4);
    repeat (5) @(negedge clk);
    ext_rst_ni = 1'b1;
    #1;
    check("R8 release no delay", int'(chip_rst_o), 0);
    @(negedge clk);
    check("R8 stays released", int'(chip_rst_o), 0);
    check("R10 ext cause kept", int'(cause_o), 4);

    // R9 wake
    osc_mode_i = 3'd2;
    @(negedge clk);
    pulse_wake(n);
    check("R9 wake crystal", n, OST);
    check("R10 wake cause", int'(cause_o), 8);
    osc_mode_i = 3'd3;
    @(negedge clk);
    pulse_wake(n);
    check("R9 wake pll", n, OST + PLL);
    osc_mode_i = 3'd0;
    @(negedge clk);
    pulse_por(n);
    osc_mode_i = 3'd6;
    @(negedge clk);
    pulse_wake(n);
    check("R9 wake ext clock", n, 0);
    check("R10 wake cause ext clk", int'(cause_o), 8);

    // R11 start-up delay counts ticks, tick every other clock
    osc_mode_i = 3'd2;
    @(negedge clk);
    wake_i = 1'b1;
    osc_tick_i = 1'b0;
    @(negedge clk);
    wake_i = 1'b0;
    osc_tick_i = 1'b1;
    n = 0;
    while (chip_rst_o && n < 1000) begin
      n++;
      @(negedge clk);
      osc_tick_i = !osc_tick_i;
    end
    osc_tick_i = 1'b1;
    check("R11 tick-paced start-up", n, 2 * OST - 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule